// File: doc/BRIEF.md
# Framed Buffered Synchronous Serial Port

This block is a full-duplex synchronous serial port. The transmit section generates its own bit clock by dividing the system clock, and it produces a one-bit-period frame pulse ahead of every word. The receive section is a slave. It takes a bit clock, a frame pulse and serial data from the pins. It oversamples them with the system clock, so it runs independently of the transmitter. Each section has its own configuration inputs: word size, bit order, clock polarity and frame polarity.

Parallel words are written into a 16-entry transmit FIFO. From there they move into a holding register and then into the shift register. A word can therefore wait in the holding register while the previous one shifts out, and consecutive words leave with no idle bit between them. The frame pulse of the next word overlaps the last bit of the current word. On the receive side, completed words go to a holding register and then into a 16-entry first-word-fall-through FIFO. They are right-justified and zero-extended. Sticky flags report a transmit frame that started with no data and a received word that was lost.

Top module: `ssp_port`

## Requirements
- R1: The word size code maps 0→8, 1→12, 2→16, 3→20, 4→24, and 5, 6 or 7→32 bits. In a continuous stream, the start of consecutive frame pulses is exactly that many bit periods apart.
- R2: Words shift most significant bit first. With code 0 (8 bits) and the lsb-first input set, bit 0 goes first. For every other size, the lsb-first input has no effect.
- R3: The bit clock pin idles at the clock-polarity input level. Transmit data changes only when the transmit bit clock leaves its idle level. The receiver samples when its bit clock returns to its idle level.
- R4: With frame polarity 0 the frame pin is active high; with 1 it is active low. The inactive level is shown while the section is disabled or idle.
- R5: The transmit bit period is div+1 system clock cycles. A div of 0 is treated as 1.
- R6: The frame pulse lasts one bit period, and the first data bit follows in the next period. The next word's pulse coincides with the current word's last bit, leaving no gap.
- R7: The transmit path stores 16 FIFO entries plus one held word. A write while tx_full is high is ignored.
- R8: When a frame starts with no held word, the port sends zeros and sets tx_underrun. The flag stays set until tx_en goes low.
- R9: Received words appear at rx_rdata (head of the FIFO, popped by rx_rd), right-justified with zeros above the word size, in the order sent.
- R10: A word that completes while the receive holding register and the receive FIFO are both full is dropped and sets rx_overrun. The flag stays set until rx_en goes low.
- R11: With rx_en low, the receiver captures nothing, even while frames arrive on its pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| tx_en | input | 1 | transmit section enable |
| tx_wlen | input | 3 | transmit word size code |
| tx_lsb_first | input | 1 | transmit LSB first (8-bit only) |
| tx_clk_pol | input | 1 | transmit bit clock idle level |
| tx_fs_pol | input | 1 | transmit frame pulse active-low when 1 |
| tx_div | input | 8 | bit clock divider value |
| tx_wr | input | 1 | write strobe |
| tx_wdata | input | 32 | word to send |
| tx_full | output | 1 | transmit FIFO full |
| tx_sclk | output | 1 | transmit bit clock |
| tx_fs | output | 1 | transmit frame pulse |
| tx_dout | output | 1 | serial data out |
| tx_underrun | output | 1 | sticky underrun flag |
| rx_en | input | 1 | receive section enable |
| rx_wlen | input | 3 | receive word size code |
| rx_lsb_first | input | 1 | receive LSB first (8-bit only) |
| rx_clk_pol | input | 1 | receive bit clock idle level |
| rx_fs_pol | input | 1 | receive frame pulse active-low when 1 |
| rx_sclk | input | 1 | receive bit clock |
| rx_fs | input | 1 | receive frame pulse |
| rx_din | input | 1 | serial data in |
| rx_rd | input | 1 | pop the head of the receive FIFO |
| rx_rdata | output | 32 | head of the receive FIFO |
| rx_empty | output | 1 | receive FIFO empty |
| rx_overrun | output | 1 | sticky overrun flag |

## Verification
The hardest situation to reach is a receive overrun. It needs the FIFO and the holding register both full at the moment another word completes, and it must keep the FIFO's order and contents intact. The bench loops the transmit pins back to the receive pins and stops reading the receive FIFO. It then streams twenty words through a transmit path that was preloaded while disabled. The first seventeen must come out in order once reading resumes, and the flag must be set before the receiver is disabled. The same loopback also exercises the underrun frame at the end of every stream. The receiver is shut down within a few bit periods of that frame, so the trailing zero word never completes.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int WORD_W = 32;
    localparam int BITS_W = $clog2(WORD_W) + 1;

    function automatic logic [BITS_W-1:0] word_bits(input logic [2:0] code);
        case (code)
            3'd0:    return BITS_W'(8);
            3'd1:    return BITS_W'(12);
            3'd2:    return BITS_W'(16);
            3'd3:    return BITS_W'(20);
            3'd4:    return BITS_W'(24);
            default: return BITS_W'(32);
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] swap8(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = w;
        for (int i = 0; i < 8; i++) r[i] = w[7-i];
        return r;
    endfunction
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (q.cnt == (AW+1)'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[q.rd];

    always_comb begin
        d = q;
        if (push_ok) d.wr = q.wr + 1'b1;
        if (pop_ok)  d.rd = q.rd + 1'b1;
        d.cnt = q.cnt + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wr] <= wdata;
    end

    p_fifo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= (AW+1)'(DEPTH));
    p_fifo_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> $stable(q.cnt));
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
    import ssp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [2:0]        wlen,
    input  logic              lsb_first,
    input  logic              clk_pol,
    input  logic              fs_pol,
    input  logic [DIV_W-1:0]  div,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              sclk,
    output logic              fs,
    output logic              dout,
    output logic              underrun
);
    typedef struct packed {
        logic [DIV_W-1:0]  cnt;
        logic              sclk;
        logic              fs;
        logic              dout;
        logic [WORD_W-1:0] sh;
        logic [BITS_W-1:0] left;
        logic [WORD_W-1:0] hold;
        logic              hval;
        logic              unr;
    } tx_st_t;

    tx_st_t q, d;
    logic [DIV_W-1:0]  last_cnt;
    logic [DIV_W:0]    half;
    logic [BITS_W-1:0] bits;
    logic [WORD_W-1:0] ordered;

    assign last_cnt = (div == '0) ? DIV_W'(1) : div;
    assign half     = ({1'b0, last_cnt} + 1'b1) >> 1;
    assign bits     = word_bits(wlen);
    assign ordered  = (lsb_first && wlen == 3'd0) ? swap8(q.hold) : q.hold;

    always_comb begin
        d = q;
        fifo_pop = 1'b0;
        if (!q.hval && !fifo_empty) begin
            d.hval   = 1'b1;
            d.hold   = fifo_data;
            fifo_pop = 1'b1;
        end
        if (!en) begin
            d.cnt  = '0;
            d.sclk = 1'b0;
            d.fs   = 1'b0;
            d.dout = 1'b0;
            d.left = '0;
            d.unr  = 1'b0;
        end else begin
            d.cnt = (q.cnt == last_cnt) ? '0 : q.cnt + 1'b1;
            if (q.cnt == '0) begin
                d.sclk = 1'b1;
                if (q.left != '0) begin
                    d.dout = q.sh[WORD_W-1];
                    d.sh   = q.sh << 1;
                end else begin
                    d.dout = 1'b0;
                end
                if (q.left <= BITS_W'(1)) begin
                    d.fs   = 1'b1;
                    d.left = bits;
                    if (q.hval) begin
                        d.sh   = ordered << (BITS_W'(WORD_W) - bits);
                        d.hval = 1'b0;
                    end else begin
                        d.sh  = '0;
                        d.unr = 1'b1;
                    end
                end else begin
                    d.fs   = 1'b0;
                    d.left = q.left - 1'b1;
                end
            end else if ({1'b0, q.cnt} == half) begin
                d.sclk = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk     = q.sclk ^ clk_pol;
    assign fs       = q.fs ^ fs_pol;
    assign dout     = q.dout;
    assign underrun = q.unr;

    p_launch_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && q.cnt != '0) |=> $stable(q.dout));
    p_fs_one_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && q.fs && q.cnt == '0) |=> !q.fs);
    p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && q.unr) |=> q.unr);
    p_left_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.left <= BITS_W'(WORD_W));
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [2:0]        wlen,
    input  logic              lsb_first,
    input  logic              clk_pol,
    input  logic              fs_pol,
    input  logic              sclk_i,
    input  logic              fs_i,
    input  logic              din_i,
    input  logic              fifo_full,
    output logic              fifo_push,
    output logic [WORD_W-1:0] fifo_data,
    output logic              overrun
);
    typedef struct packed {
        logic              sclk_s;
        logic              sclk_p;
        logic              fs_s;
        logic              din_s;
        logic [WORD_W-1:0] sh;
        logic [BITS_W-1:0] left;
        logic [WORD_W-1:0] hold;
        logic              hval;
        logic              ovr;
    } rx_st_t;

    rx_st_t q, d;
    logic [BITS_W-1:0] bits;
    logic [WORD_W:0]   mask_x;
    logic [WORD_W-1:0] mask, sh_new, word;
    logic              sample;

    assign bits   = word_bits(wlen);
    assign mask_x = ((WORD_W+1)'(1) << bits) - 1'b1;
    assign mask   = mask_x[WORD_W-1:0];
    assign sample = q.sclk_p && !q.sclk_s;
    assign sh_new = {q.sh[WORD_W-2:0], q.din_s};
    assign word   = (lsb_first && wlen == 3'd0) ? swap8(sh_new & mask) : (sh_new & mask);

    always_comb begin
        d = q;
        fifo_push = 1'b0;
        d.sclk_s = sclk_i ^ clk_pol;
        d.sclk_p = q.sclk_s;
        d.fs_s   = fs_i ^ fs_pol;
        d.din_s  = din_i;
        if (q.hval && !fifo_full) begin
            fifo_push = 1'b1;
            d.hval    = 1'b0;
        end
        if (!en) begin
            d.left = '0;
            d.ovr  = 1'b0;
        end else if (sample) begin
            if (q.left != '0) begin
                d.sh = sh_new;
                if (q.left == BITS_W'(1)) begin
                    if (q.hval && fifo_full) begin
                        d.ovr = 1'b1;
                    end else begin
                        d.hold = word;
                        d.hval = 1'b1;
                    end
                end
            end
            if (q.fs_s)               d.left = bits;
            else if (q.left != '0)    d.left = q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fifo_data = q.hold;
    assign overrun   = q.ovr;

    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && q.ovr) |=> q.ovr);
    p_zero_extend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hval && !$stable(q.hold)) |-> ((q.hold & ~mask) == '0));
    p_idle_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q.left == '0));
endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [2:0]        tx_wlen,
    input  logic              tx_lsb_first,
    input  logic              tx_clk_pol,
    input  logic              tx_fs_pol,
    input  logic [DIV_W-1:0]  tx_div,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_wdata,
    output logic              tx_full,
    output logic              tx_sclk,
    output logic              tx_fs,
    output logic              tx_dout,
    output logic              tx_underrun,
    input  logic              rx_en,
    input  logic [2:0]        rx_wlen,
    input  logic              rx_lsb_first,
    input  logic              rx_clk_pol,
    input  logic              rx_fs_pol,
    input  logic              rx_sclk,
    input  logic              rx_fs,
    input  logic              rx_din,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_rdata,
    output logic              rx_empty,
    output logic              rx_overrun
);
    logic              txf_empty, txf_pop, rxf_full, rxf_push;
    logic [WORD_W-1:0] txf_data, rxf_data;

    ssp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .push(tx_wr), .wdata(tx_wdata),
        .pop(txf_pop), .rdata(txf_data), .full(tx_full), .empty(txf_empty)
    );

    ssp_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .wlen(tx_wlen),
        .lsb_first(tx_lsb_first), .clk_pol(tx_clk_pol), .fs_pol(tx_fs_pol),
        .div(tx_div), .fifo_empty(txf_empty), .fifo_data(txf_data),
        .fifo_pop(txf_pop), .sclk(tx_sclk), .fs(tx_fs), .dout(tx_dout),
        .underrun(tx_underrun)
    );

    ssp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .wlen(rx_wlen),
        .lsb_first(rx_lsb_first), .clk_pol(rx_clk_pol), .fs_pol(rx_fs_pol),
        .sclk_i(rx_sclk), .fs_i(rx_fs), .din_i(rx_din), .fifo_full(rxf_full),
        .fifo_push(rxf_push), .fifo_data(rxf_data), .overrun(rx_overrun)
    );

    ssp_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .push(rxf_push), .wdata(rxf_data),
        .pop(rx_rd), .rdata(rx_rdata), .full(rxf_full), .empty(rx_empty)
    );
endmodule

// File: tb/ssp_port_test.sv
module ssp_port_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic tx_en = 0, rx_en = 0, tx_wr = 0, rx_rd = 0;
    logic [2:0] wlen = 0;
    logic lsb = 0, cpol = 0, fpol = 0;
    logic [7:0] dv = 8'd1;
    logic [31:0] tx_wdata = 0;
    logic tx_full, tx_sclk, tx_fs, tx_dout, tx_underrun, rx_empty, rx_overrun;
    logic [31:0] rx_rdata;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit pop_en = 1;
    logic [31:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    ssp_port uut (
        .clk(clk), .rst_n(rst_n),
        .tx_en(tx_en), .tx_wlen(wlen), .tx_lsb_first(lsb), .tx_clk_pol(cpol),
        .tx_fs_pol(fpol), .tx_div(dv), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .tx_full(tx_full), .tx_sclk(tx_sclk), .tx_fs(tx_fs), .tx_dout(tx_dout),
        .tx_underrun(tx_underrun),
        .rx_en(rx_en), .rx_wlen(wlen), .rx_lsb_first(lsb), .rx_clk_pol(cpol),
        .rx_fs_pol(fpol), .rx_sclk(tx_sclk), .rx_fs(tx_fs), .rx_din(tx_dout),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_empty(rx_empty),
        .rx_overrun(rx_overrun)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int nbits(input logic [2:0] c);
        case (c)
            3'd0: return 8;   3'd1: return 12;  3'd2: return 16;
            3'd3: return 20;  3'd4: return 24;  default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] trim(input logic [31:0] w);
        int b = nbits(wlen);
        return (b == 32) ? w : (w & ((32'd1 << b) - 1));
    endfunction

    function automatic int period();
        return (dv == 0) ? 2 : int'(dv) + 1;
    endfunction

    // scoreboard monitor: pops the receive FIFO and compares with the queue
    initial begin
        forever begin
            @(negedge clk);
            rx_rd = 0;
            if (pop_en && !rx_empty) begin
                if (exp_q.size() == 0)
                    check(0, "R9 unexpected word", rx_rdata, 0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(rx_rdata == e, "R9 word order/value", rx_rdata, e);
                end
                rx_rd = 1;
            end
        end
    end

    initial begin
        wait (cyc > 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // driver: preload while disabled, stream, wait for end-of-data underrun
    task automatic batch(input int n, input bit force_wr, input int keep,
                         input bit rx_on, input bit probe, input logic [31:0] first);
        bit on = 0;
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = (i == 0) ? first : (32'hA5C3_0F00 ^ (i * 32'h01F3_5B27));
            if (!force_wr) begin
                if (!on && i == 17) begin tx_en = 1; rx_en = rx_on; on = 1; end
                while (tx_full) @(negedge clk);
            end
            tx_wr = 1; tx_wdata = w;
            @(negedge clk);
            tx_wr = 0;
            if (i < keep) exp_q.push_back(trim(w));
        end
        if (!on) begin tx_en = 1; rx_en = rx_on; end
        if (probe) begin
            logic [31:0] w0;
            logic eb;
            w0 = trim(first);
            eb = (lsb && wlen == 0) ? w0[0] : w0[nbits(wlen)-1];
            while ((tx_fs ^ fpol) == 0) @(negedge clk);
            while ((tx_fs ^ fpol) == 1) @(negedge clk);
            check(tx_dout == eb, "R2/R6 first data bit", tx_dout, eb);
        end
        while (!tx_underrun) @(negedge clk);
        check(tx_underrun == 1, "R8 underrun after last word", tx_underrun, 1);
        if (!pop_en)
            check(rx_overrun == (n > 17), "R10 overrun flag", rx_overrun, n > 17);
        repeat (3 * period()) @(negedge clk);
        tx_en = 0; rx_en = 0;
        @(negedge clk);
        check(tx_underrun == 0, "R8 cleared by disable", tx_underrun, 0);
        check(rx_overrun == 0, "R10 cleared by disable", rx_overrun, 0);
        pop_en = 1;
        repeat (200) @(negedge clk);
        check(exp_q.size() == 0, "R9 all words received", exp_q.size(), 0);
    endtask

    task automatic measure(input int exp_sclk, input int exp_frame);
        int t0;
        while ((tx_sclk ^ cpol) == 1) @(negedge clk);
        while ((tx_sclk ^ cpol) == 0) @(negedge clk);
        t0 = cyc;
        while ((tx_sclk ^ cpol) == 1) @(negedge clk);
        while ((tx_sclk ^ cpol) == 0) @(negedge clk);
        check(cyc - t0 == exp_sclk, "R5 bit period", cyc - t0, exp_sclk);
        while ((tx_fs ^ fpol) == 1) @(negedge clk);
        while ((tx_fs ^ fpol) == 0) @(negedge clk);
        t0 = cyc;
        while ((tx_fs ^ fpol) == 1) @(negedge clk);
        while ((tx_fs ^ fpol) == 0) @(negedge clk);
        check(cyc - t0 == exp_frame, "R1/R6 frame spacing", cyc - t0, exp_frame);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(tx_sclk == 0, "R3 reset clock idle", tx_sclk, 0);
        check(tx_fs == 0, "R4 reset frame idle", tx_fs, 0);
        check(tx_dout == 0, "R6 reset data", tx_dout, 0);
        check(rx_empty == 1, "R9 reset empty", rx_empty, 1);
        check(tx_underrun == 0 && rx_overrun == 0, "R8/R10 reset flags",
              {tx_underrun, rx_overrun}, 0);

        // 8-bit MSB first
        wlen = 0; lsb = 0; dv = 1;
        batch(10, 0, 10, 1, 1, 32'hFFFF_FF01);
        // 8-bit LSB first
        lsb = 1;
        batch(6, 0, 6, 1, 1, 32'h0000_0001);
        // 16-bit: lsb option ignored
        wlen = 2; lsb = 1;
        batch(6, 0, 6, 1, 1, 32'h1234_8000);
        lsb = 0;
        // remaining sizes with timing measurements
        wlen = 1; dv = 3;
        fork
            batch(6, 0, 6, 1, 0, 32'hABCD_E123);
            measure(4, 12 * 4);
        join
        wlen = 3; dv = 0;
        fork
            batch(5, 0, 5, 1, 0, 32'h7777_7777);
            measure(2, 20 * 2);
        join
        wlen = 4; dv = 2;
        batch(5, 0, 5, 1, 1, 32'h00C0_FFEE);
        wlen = 5; dv = 4;
        batch(4, 0, 4, 1, 1, 32'hDEAD_BEEF);
        wlen = 7; dv = 1;
        fork
            batch(4, 0, 4, 1, 0, 32'h8000_0001);
            measure(2, 32 * 2);
        join
        // inverted polarities
        wlen = 0; cpol = 1; fpol = 1; dv = 2;
        batch(8, 0, 8, 1, 1, 32'h0000_0080);
        check(tx_sclk == 1, "R3 inverted clock idle", tx_sclk, 1);
        check(tx_fs == 1, "R4 active-low frame idle", tx_fs, 1);
        cpol = 0; fpol = 0; dv = 1;
        // writes while full are ignored
        batch(20, 1, 17, 1, 0, 32'h0000_0011);
        // receiver disabled: nothing captured
        batch(4, 0, 0, 0, 0, 32'h0000_0055);
        check(rx_empty == 1, "R11 disabled receiver", rx_empty, 1);
        // overrun: reader stalled
        pop_en = 0;
        batch(20, 0, 17, 1, 0, 32'h0000_0022);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule